// File: doc/BRIEF.md
# Boot Image Loader and Launcher

After reset this block pulls a program image out of a valid/ready preload stream and writes it, word by word, into instruction memory through a simple write port. The stream starts with a length word that says how many image words follow. The length word itself is never stored. The image word that lands at address 0 has a second role: it describes the first code bag to fetch, with a size in its low bits and a base address above them.

Once the final image word has been written, the block sends a single launch request to the fetch engine. The request carries the captured base and size, and a sticky launched flag rises at the same time. From then on the preload port is closed until the next reset.

The stream can be built from bytes, with six bytes forming one word most-significant byte first, or from whole words. A parameter selects between the two.

Top module: `boot_loader`

## Requirements
- R1: During and right after reset, `preReady` is 1 and `memWe`, `launchReq` and `launched` are 0.
- R2: The first word accepted after reset is the length, and it is never written to memory. Only its low ADDR_W+1 bits (15 by default) are used as the count.
- R3: Each image word is written to the next memory address, starting at 0 and in arrival order. `memWe` is high for exactly one cycle, in the cycle after the edge that accepts the word's last byte.
- R4: In byte mode, six accepted bytes form one 48-bit word, most-significant byte first. Cycles where `preValid` is low do not disturb the assembly.
- R5: The word written at address 0 sets the launch descriptor. Its bits [5:0] give `launchSize` and its bits [23:6] give the 18-bit `launchBase`. Any bits above 23 are dropped, and later image words leave the descriptor unchanged.
- R6: `launchReq` is a single-cycle pulse that occurs one cycle after the write pulse of the last image word. `launched` rises in that same cycle and stays high until reset.
- R7: Once `launched` is high, `preReady` stays 0 and preload input has no effect: no further writes and no further launch.
- R8: A length of zero produces no write and no launch. `preReady` drops to 0 and `launched` stays 0 until reset.
- R9: While the length or image words are being taken, `preReady` is held at 1, so the block never stalls the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| preValid | input | 1 | Preload stream valid |
| preReady | output | 1 | Preload stream ready |
| preData | input | IN_W (8) | Preload byte, or a whole word in word mode |
| memWe | output | 1 | Instruction memory write enable |
| memAddr | output | ADDR_W (14) | Write address |
| memData | output | 48 | Write data |
| launchReq | output | 1 | One-cycle launch request to the fetch engine |
| launchBase | output | BASE_W (18) | Code-bag base address |
| launchSize | output | SIZE_W (6) | Code-bag size |
| launched | output | 1 | Set when the launch is issued |

## Verification
The hardest case to reach from the ports is the boundary around the final image word. Launch timing, the closing of the port and input arriving after launch all meet at that point. The driver records the edge that accepts the last byte and predicts the launch cycle from it. It then keeps offering bytes after launch and checks that nothing reaches memory. Separate resets reach the empty-image case, a length word with junk in its high bits, and a one-word image whose descriptor also ends the load.

// File: rtl/boot_pkg.sv
package boot_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptEn;   // stream may be consumed this cycle
    logic takeLen;    // completed word is the length
    logic takeWord;   // completed word is an image word
    logic fireLaunch; // issue the launch request
  } bootCtl_t;

  typedef enum logic [1:0] {
    ST_LEN   = 2'd0,
    ST_LOAD  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_HALT  = 2'd3
  } bootState_t;

endpackage

// File: rtl/boot_datapath.sv
module boot_datapath
  import boot_pkg::*;
#(
  parameter int WORD_BYTES = 6,
  parameter bit BYTE_MODE  = 1'b1,
  parameter int IN_W       = 8,
  parameter int ADDR_W     = 14,
  parameter int BASE_W     = 18,
  parameter int SIZE_W     = 6,
  parameter int LEN_W      = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bootCtl_t                  ctl,
  input  logic                      preValid,
  input  logic [IN_W-1:0]           preData,
  output logic                      wordFire,
  output logic                      lenZero,
  output logic                      lastWord,
  output logic                      memWe,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [8*WORD_BYTES-1:0]   memData,
  output logic                      launchReq,
  output logic [BASE_W-1:0]         launchBase,
  output logic [SIZE_W-1:0]         launchSize,
  output logic                      launched
);

  localparam int WORD_W = 8 * WORD_BYTES;

  logic              accept;
  logic [WORD_W-1:0] wordVal;
  logic [LEN_W-1:0]  lenLeft;
  logic [ADDR_W-1:0] addrCnt;
  logic              firstPending;

  assign accept = preValid & ctl.acceptEn;

  generate
    if (BYTE_MODE) begin : g_bytes
      localparam int SH_W  = WORD_W - 8;
      localparam int IDX_W = $clog2(WORD_BYTES);
      logic [SH_W-1:0]  shReg;
      logic [IDX_W-1:0] byteIdx;
      logic             lastByte;

      assign lastByte = (byteIdx == IDX_W'(WORD_BYTES - 1));
      assign wordFire = accept & lastByte;
      assign wordVal  = {shReg, preData};

      always_ff @(posedge clk) begin
        if (rst) begin
          shReg   <= '0;
          byteIdx <= '0;
        end else if (accept) begin
          shReg   <= SH_W'({shReg, preData});
          byteIdx <= lastByte ? '0 : byteIdx + 1'b1;
        end
      end
    end else begin : g_words
      assign wordFire = accept;
      assign wordVal  = preData;
    end
  endgenerate

  assign lenZero  = (wordVal[LEN_W-1:0] == '0);
  assign lastWord = (lenLeft == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lenLeft      <= '0;
      addrCnt      <= '0;
      firstPending <= 1'b1;
      memWe        <= 1'b0;
      memAddr      <= '0;
      memData      <= '0;
      launchBase   <= '0;
      launchSize   <= '0;
      launchReq    <= 1'b0;
      launched     <= 1'b0;
    end else begin
      memWe     <= 1'b0;
      launchReq <= 1'b0;
      if (ctl.takeLen) begin
        lenLeft <= wordVal[LEN_W-1:0];
      end
      if (ctl.takeWord) begin
        memWe   <= 1'b1;
        memAddr <= addrCnt;
        memData <= wordVal;
        addrCnt <= addrCnt + 1'b1;
        lenLeft <= lenLeft - 1'b1;
        if (firstPending) begin
          firstPending <= 1'b0;
          launchBase   <= wordVal[SIZE_W +: BASE_W];
          launchSize   <= wordVal[SIZE_W-1:0];
        end
      end
      if (ctl.fireLaunch) begin
        launchReq <= 1'b1;
        launched  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/boot_control.sv
module boot_control
  import boot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wordFire,
  input  logic     lenZero,
  input  logic     lastWord,
  output bootCtl_t ctl
);

  bootState_t state, stateNext;

  always_comb begin
    ctl            = '0;
    stateNext      = state;
    ctl.acceptEn   = (state == ST_LEN) || (state == ST_LOAD);
    ctl.takeLen    = (state == ST_LEN) && wordFire;
    ctl.takeWord   = (state == ST_LOAD) && wordFire;
    ctl.fireLaunch = (state == ST_FLUSH);
    unique case (state)
      ST_LEN:   if (wordFire) stateNext = lenZero ? ST_HALT : ST_LOAD;
      ST_LOAD:  if (wordFire && lastWord) stateNext = ST_FLUSH;
      ST_FLUSH: stateNext = ST_HALT;
      default:  stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LEN;
    else     state <= stateNext;
  end

endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int WORD_BYTES = 6,
  parameter bit BYTE_MODE  = 1'b1,
  parameter int IN_W       = BYTE_MODE ? 8 : 8 * WORD_BYTES,
  parameter int ADDR_W     = 14,
  parameter int BASE_W     = 18,
  parameter int SIZE_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    preValid,
  output logic                    preReady,
  input  logic [IN_W-1:0]         preData,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [8*WORD_BYTES-1:0] memData,
  output logic                    launchReq,
  output logic [BASE_W-1:0]       launchBase,
  output logic [SIZE_W-1:0]       launchSize,
  output logic                    launched
);

  localparam int LEN_W = ADDR_W + 1;

  bootCtl_t ctl;
  logic     wordFire, lenZero, lastWord;

  assign preReady = ctl.acceptEn;

  boot_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wordFire (wordFire),
    .lenZero  (lenZero),
    .lastWord (lastWord),
    .ctl      (ctl)
  );

  boot_datapath #(
    .WORD_BYTES (WORD_BYTES),
    .BYTE_MODE  (BYTE_MODE),
    .IN_W       (IN_W),
    .ADDR_W     (ADDR_W),
    .BASE_W     (BASE_W),
    .SIZE_W     (SIZE_W),
    .LEN_W      (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .preValid   (preValid),
    .preData    (preData),
    .wordFire   (wordFire),
    .lenZero    (lenZero),
    .lastWord   (lastWord),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memData    (memData),
    .launchReq  (launchReq),
    .launchBase (launchBase),
    .launchSize (launchSize),
    .launched   (launched)
  );

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk (
  input logic clk,
  input logic rst,
  input logic preReady,
  input logic memWe,
  input logic launchReq,
  input logic launched
);

  assert_launch_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    launchReq |=> !launchReq);

  assert_launch_follows_write_R6: assert property (@(posedge clk) disable iff (rst)
    launchReq |-> $past(memWe));

  assert_flag_rises_with_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(launched) |-> launchReq);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    launched |=> launched);

  assert_closed_after_launch_R7: assert property (@(posedge clk) disable iff (rst)
    launched |-> (!preReady && !memWe));

endmodule

bind boot_loader boot_loader_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .preReady  (preReady),
  .memWe     (memWe),
  .launchReq (launchReq),
  .launched  (launched)
);

// File: tb/boot_loader_tb.sv
module boot_loader_tb_top;

  localparam int ADDR_W = 14;
  localparam int WORD_W = 48;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              preValid = 1'b0;
  logic [7:0]        preData = '0;
  logic              preReady, memWe, launchReq, launched;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memData;
  logic [17:0]       launchBase;
  logic [5:0]        launchSize;

  always #4 clk = ~clk; // 125 MHz

  boot_loader dut_i (
    .clk(clk), .rst(rst), .preValid(preValid), .preReady(preReady),
    .preData(preData), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .launchReq(launchReq), .launchBase(launchBase), .launchSize(launchSize),
    .launched(launched)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycCnt  = 0;
  int lastAccCyc = 0;
  int expLaunchCyc = -1;
  int launchSeen = 0;
  bit launchAllowed = 1'b0;
  logic [17:0] expBase;
  logic [5:0]  expSize;
  logic [ADDR_W+WORD_W-1:0] expQ[$];

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected write", {50'd0, memAddr}, 64'd0);
      end else begin
        logic [ADDR_W+WORD_W-1:0] e;
        e = expQ.pop_front();
        check({memAddr, memData} == e, "R3 write addr/data",
              64'({memAddr, memData}), 64'(e));
      end
    end
    if (!rst && launchReq) begin
      launchSeen++;
      check(launchAllowed, "R7 R8 launch not allowed", 64'd1, 64'd0);
      check(cycCnt == expLaunchCyc, "R6 launch cycle", 64'(cycCnt), 64'(expLaunchCyc));
      check(launchBase == expBase, "R5 base", 64'(launchBase), 64'(expBase));
      check(launchSize == expSize, "R5 size", 64'(launchSize), 64'(expSize));
      launchAllowed = 1'b0;
    end
  end

  task automatic doReset();
    preValid = 1'b0;
    rst = 1'b1;
    expQ.delete();
    launchSeen = 0;
    launchAllowed = 1'b0;
    expLaunchCyc = -1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input int gap);
    preValid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    preValid = 1'b1;
    preData  = b;
    @(negedge clk);
    check(preReady == 1'b1, "R9 ready while loading", 64'(preReady), 64'd1);
    @(posedge clk);
    #1;
    lastAccCyc = cycCnt;
    preValid = 1'b0;
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] w, input int gap);
    for (int b = 5; b >= 0; b--) sendByte(w[b*8 +: 8], gap);
  endtask

  // driver: pushes expected writes, then sends an image word
  task automatic sendImageWord(input int addr, input logic [WORD_W-1:0] w, input int gap);
    expQ.push_back({ADDR_W'(addr), w});
    sendWord(w, gap);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  logic [WORD_W-1:0] img [4];

  initial begin
    // watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    img[0] = {24'hC35A99, 18'h2F0E1, 6'd41};
    img[1] = 48'h0123_4567_89AB;
    img[2] = 48'hFEDC_BA98_7654;
    img[3] = 48'h5555_AAAA_0F0F;

    // R1 reset state
    doReset();
    @(negedge clk);
    check(preReady == 1'b1, "R1 ready", 64'(preReady), 64'd1);
    check(memWe == 1'b0, "R1 memWe", 64'(memWe), 64'd0);
    check(launchReq == 1'b0, "R1 launchReq", 64'(launchReq), 64'd0);
    check(launched == 1'b0, "R1 launched", 64'(launched), 64'd0);
    @(posedge clk); #1;

    // Test A: four-word image, length word not stored (R2), bytes MSB first (R4)
    expBase = 18'h2F0E1; expSize = 6'd41; launchAllowed = 1'b1;
    sendWord(48'd4, 0);
    for (int i = 0; i < 4; i++) begin
      sendImageWord(i, img[i], 0);
      if (i == 3) expLaunchCyc = lastAccCyc + 1;
    end
    wait_cycles(3);
    check(launchSeen == 1, "R6 single launch", 64'(launchSeen), 64'd1);
    check(launched == 1'b1, "R6 launched flag", 64'(launched), 64'd1);
    check(expQ.size() == 0, "R2 R3 write count", 64'(expQ.size()), 64'd0);
    // post-launch input is ignored (R7)
    preValid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      preData = 8'(8'hA0 + i);
      @(negedge clk);
      check(preReady == 1'b0, "R7 ready low after launch", 64'(preReady), 64'd0);
      @(posedge clk); #1;
    end
    preValid = 1'b0;
    wait_cycles(3);
    check(launchSeen == 1, "R7 no second launch", 64'(launchSeen), 64'd1);
    check(launched == 1'b1, "R7 flag held", 64'(launched), 64'd1);

    // Test B: zero length (R8)
    doReset();
    sendWord(48'd0, 1);
    wait_cycles(10);
    check(preReady == 1'b0, "R8 ready low", 64'(preReady), 64'd0);
    check(launched == 1'b0, "R8 no launched flag", 64'(launched), 64'd0);
    check(launchSeen == 0, "R8 no launch", 64'(launchSeen), 64'd0);

    // Test C: junk in length high bits (R2), gaps between bytes (R4), max descriptor (R5)
    doReset();
    expBase = 18'h3FFFF; expSize = 6'd63; launchAllowed = 1'b1;
    sendWord(48'hFFFF_FFFF_0002, 2);
    sendImageWord(0, {24'h000001, 18'h3FFFF, 6'd63}, 2);
    check(launchSeen == 0, "R2 length low bits only", 64'(launchSeen), 64'd0);
    sendImageWord(1, {24'hFFFFFF, 18'h00000, 6'd0}, 3);
    expLaunchCyc = lastAccCyc + 1;
    wait_cycles(4);
    check(launchSeen == 1, "R6 launch after two words", 64'(launchSeen), 64'd1);
    check(launchBase == 18'h3FFFF, "R5 descriptor kept", 64'(launchBase), 64'h3FFFF);
    check(expQ.size() == 0, "R3 write count", 64'(expQ.size()), 64'd0);

    // Test D: one-word image
    doReset();
    expBase = 18'h00001; expSize = 6'd0; launchAllowed = 1'b1;
    sendWord(48'd1, 0);
    sendImageWord(0, {24'hABCDEF, 18'h00001, 6'd0}, 0);
    expLaunchCyc = lastAccCyc + 1;
    wait_cycles(4);
    check(launchSeen == 1, "R6 one-word launch", 64'(launchSeen), 64'd1);
    check(expQ.size() == 0, "R3 single write", 64'(expQ.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule